// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Store

This block models a one-bit-wide configuration memory that a loader reads out serially over a clock it shares with the block. An internal counter selects one stored bit. That bit is placed on a tri-state serial output, and the counter moves on by one on each rising clock edge. The block does not care whether the loader makes the clock or an outside source clocks both parts. It acts only on the edges it sees.

Several instances can sit on one clock line and one data line. The first instance's enable is driven from outside. Each later instance takes its enable from the cascade output of the one before it. When an instance has sent its last bit, it releases the shared line and raises its cascade output, so the next instance continues the stream without a gap. A combined reset / output-enable pin stops the stream. Its active level is set by a parameter. While that pin is in reset, a small write port fills the bit array.

Top module: `serial_cfg_store`

## Requirements
- R1: While the reset/output-enable pin is at its reset level, the counter is zero, `dataOe` is 0 and `cascadeOut` is 0.
- R2: Parameter `RST_POL` sets the reset level of `rstOe`. A value of 1 means `rstOe`=1 resets, and a value of 0 means `rstOe`=0 resets. The pin's other level lets the block run.
- R3: Out of reset, with `chipEn`=1 and the counter below `2**ADDR_W`, `dataOe` is 1. `dataOut` then shows the stored bit whose address equals the counter, and each rising clock edge raises the counter by exactly one. After reset, bit 0 is shown first.
- R4: After `2**ADDR_W` enabled edges the counter reaches its terminal value and stops there. `dataOe` goes to 0 and `cascadeOut` goes to 1.
- R5: With `chipEn`=0 the counter holds, `dataOe` is 0 and `cascadeOut` is 0. Streaming continues from the held address when `chipEn` returns to 1.
- R6: A write (`wrEn`=1) stores `wrData` at `wrAddr` on a rising edge only while the block is in reset. Writes made outside reset leave the stored bits unchanged.
- R7: In a chain of three instances with each `cascadeOut` feeding the next `chipEn`, exactly one instance drives the shared line on each cycle until the last one finishes. The combined stream equals the three stored patterns joined in chain order, with no gap and no overlap.
- R8: `cascadeOut` goes to 0 as soon as `chipEn` goes to 0, even at terminal count. This shuts off the rest of the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock shared with the loader |
| chipEn | input | 1 | Enable, active high; fed by the previous cascade output in a chain |
| rstOe | input | 1 | Combined reset / output-enable pin; reset level set by `RST_POL` |
| wrEn | input | 1 | Preload write strobe, effective only in reset |
| wrAddr | input | ADDR_W | Preload bit address |
| wrData | input | 1 | Preload bit value |
| dataOut | output | 1 | Serial data, high impedance when not driving |
| dataOe | output | 1 | High while this instance drives `dataOut` |
| cascadeOut | output | 1 | Terminal-count enable for the next instance |

## Verification
The hardest situation to reach is the handoff between instances. One instance must release the shared line in the same cycle that the next one starts with its bit 0, and an enable must drop while an instance sits at terminal count. The bench builds a three-instance chain, with the middle instance set to the opposite reset polarity. It preloads each instance with a pattern computed from a seed, then checks the joined line bit by bit across the whole chain for several seeds. It also pauses the chain in mid-stream and drops the head enable once all three instances have finished.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef struct packed {
    logic load;   // array write permitted this cycle
    logic drive;  // serial output owns the shared line
  } scsStrobe_t;
endpackage

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter bit RST_POL = 1'b1
) (
  input  logic            clk,
  input  logic            chipEn,
  input  logic            rstOe,
  input  logic            wrEn,
  output logic [ADDR_W:0] bitCount,
  output scsStrobe_t      strobe,
  output logic            cascadeOut
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(DEPTH);

  logic inReset;
  logic atEnd;

  assign inReset = (rstOe == RST_POL);
  assign atEnd   = (bitCount == TERM);

  always_ff @(posedge clk or posedge inReset) begin
    if (inReset) begin
      bitCount <= '0;
    end else if (chipEn && !atEnd) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  always_comb begin
    strobe.load  = inReset && wrEn;
    strobe.drive = !inReset && chipEn && !atEnd;
    cascadeOut   = !inReset && chipEn && atEnd;
  end

  AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (inReset)
    bitCount <= TERM); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (inReset)
    (chipEn && bitCount != TERM) |=> (bitCount == $past(bitCount) + 1'b1)); // R3
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (inReset)
    (bitCount == TERM) |=> (bitCount == TERM)); // R4
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (inReset)
    !chipEn |=> $stable(bitCount)); // R5
  AST_CASCADE_EXCL: assert property (@(posedge clk) disable iff (inReset)
    cascadeOut |-> !strobe.drive); // R7
endmodule

// File: rtl/scs_datapath.sv
module scs_datapath
  import scs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  scsStrobe_t        strobe,
  input  logic [ADDR_W-1:0] readAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrData,
  output logic              dataOut,
  output logic              dataOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0] memBits;
  logic             selBit;

  always_ff @(posedge clk) begin
    if (strobe.load) begin
      memBits[wrAddr] <= wrData;
    end
  end

  assign selBit  = memBits[readAddr];
  assign dataOe  = strobe.drive;
  assign dataOut = dataOe ? selBit : 1'bz;

  AST_ARRAY_FROZEN: assert property (@(posedge clk)
    strobe.drive |=> $stable(memBits)); // R6
  always_comb begin
    AST_NO_DRIVE_WHILE_LOAD: assert (!(strobe.load && dataOe)); // R1
  end
endmodule

// File: rtl/serial_cfg_store.sv
module serial_cfg_store
  import scs_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter bit RST_POL = 1'b1
) (
  input  logic              clk,
  input  logic              chipEn,
  input  logic              rstOe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrData,
  output logic              dataOut,
  output logic              dataOe,
  output logic              cascadeOut
);
  scsStrobe_t      strobe;
  logic [ADDR_W:0] bitCount;

  scs_ctrl #(.ADDR_W(ADDR_W), .RST_POL(RST_POL)) uCtrl (
    .clk(clk), .chipEn(chipEn), .rstOe(rstOe), .wrEn(wrEn),
    .bitCount(bitCount), .strobe(strobe), .cascadeOut(cascadeOut)
  );

  scs_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk(clk), .strobe(strobe), .readAddr(bitCount[ADDR_W-1:0]),
    .wrAddr(wrAddr), .wrData(wrData), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/sim_serial_cfg_store.sv
`timescale 1ns/1ps
module sim_serial_cfg_store;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstHigh, chainEn, wrData;
  logic wrEn0, wrEn1, wrEn2;
  logic [AW-1:0] wrAddr;
  wire  serialLine;
  logic oe0, oe1, oe2, casc0, casc1, casc2;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  serial_cfg_store #(.ADDR_W(AW), .RST_POL(1'b1)) u0 (
    .clk(clk), .chipEn(chainEn), .rstOe(rstHigh), .wrEn(wrEn0), .wrAddr(wrAddr),
    .wrData(wrData), .dataOut(serialLine), .dataOe(oe0), .cascadeOut(casc0));
  serial_cfg_store #(.ADDR_W(AW), .RST_POL(1'b0)) u1 (
    .clk(clk), .chipEn(casc0), .rstOe(~rstHigh), .wrEn(wrEn1), .wrAddr(wrAddr),
    .wrData(wrData), .dataOut(serialLine), .dataOe(oe1), .cascadeOut(casc1));
  serial_cfg_store #(.ADDR_W(AW), .RST_POL(1'b1)) u2 (
    .clk(clk), .chipEn(casc1), .rstOe(rstHigh), .wrEn(wrEn2), .wrAddr(wrAddr),
    .wrData(wrData), .dataOut(serialLine), .dataOe(oe2), .cascadeOut(casc2));

  function automatic logic expBit(int dev, int idx, int seed);
    int v;
    v = idx * (2 * dev + 3) + seed * 11 + dev * 5 + (idx >> 2);
    return ^(v[7:0]);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loadAll(int seed, bit invert);
    for (int d = 0; d < 3; d++) begin
      for (int a = 0; a < DEPTH; a++) begin
        @(negedge clk);
        wrAddr = AW'(a);
        wrData = expBit(d, a, seed) ^ invert;
        wrEn0 = (d == 0); wrEn1 = (d == 1); wrEn2 = (d == 2);
      end
    end
    @(negedge clk);
    wrEn0 = 0; wrEn1 = 0; wrEn2 = 0;
  endtask

  task automatic streamChain(int seed);
    for (int k = 0; k < 3 * DEPTH; k++) begin
      int owner = k / DEPTH;
      if (k != 0) @(negedge clk);
      #1;
      check("R7", {5'd0, oe2, oe1, oe0}, 8'(1 << owner), $sformatf("owner at bit %0d", k));
      if (owner == 1)
        check("R2", 8'(serialLine), 8'(expBit(1, k % DEPTH, seed)), $sformatf("low-pol dev bit %0d", k));
      else
        check("R3", 8'(serialLine), 8'(expBit(owner, k % DEPTH, seed)), $sformatf("stream bit %0d", k));
    end
    @(negedge clk); #1;
    check("R4", {5'd0, oe2, oe1, oe0}, 8'd0, "no driver after end");
    check("R4", {5'd0, casc2, casc1, casc0}, 8'd7, "cascade at end");
  endtask

  initial begin
    rstHigh = 1; chainEn = 1; wrEn0 = 0; wrEn1 = 0; wrEn2 = 0; wrAddr = '0; wrData = 0;
    repeat (2) @(negedge clk);
    #1;
    check("R1", {5'd0, oe2, oe1, oe0}, 8'd0, "no drive in reset");
    check("R1", {5'd0, casc2, casc1, casc0}, 8'd0, "no cascade in reset");

    for (int seed = 0; seed < 3; seed++) begin
      rstHigh = 1;
      loadAll(seed, 1'b0);
      @(negedge clk); #1;
      check("R1", {7'd0, oe1}, 8'd0, "low-pol dev off in reset");
      @(negedge clk);
      rstHigh = 0;
      streamChain(seed);
    end

    // R6: writes outside reset must not alter the array
    loadAll(2, 1'b1);
    @(negedge clk); rstHigh = 1;
    @(negedge clk); rstHigh = 0;
    streamChain(2);

    // R8: dropping head enable at terminal count clears all cascades
    @(negedge clk); chainEn = 0; #1;
    check("R8", {5'd0, casc2, casc1, casc0}, 8'd0, "cascade off with enable low");
    check("R8", {5'd0, oe2, oe1, oe0}, 8'd0, "no driver with enable low");

    // R5: pause mid-stream and resume from held address
    @(negedge clk); rstHigh = 1; chainEn = 1;
    @(negedge clk); rstHigh = 0;
    repeat (5) @(negedge clk);
    #1;
    check("R5", 8'(serialLine), 8'(expBit(0, 5, 2)), "bit before pause");
    chainEn = 0; #1;
    check("R5", {6'd0, casc0, oe0}, 8'd0, "paused outputs");
    repeat (3) @(negedge clk);
    chainEn = 1; #1;
    check("R5", {7'd0, oe0}, 8'd1, "drive after resume");
    check("R5", 8'(serialLine), 8'(expBit(0, 5, 2)), "held address after pause");
    @(negedge clk); #1;
    check("R3", 8'(serialLine), 8'(expBit(0, 6, 2)), "advance after resume");

    // R1: reset in mid-stream shuts drive off at once
    rstHigh = 1; #1;
    check("R1", {6'd0, casc0, oe0}, 8'd0, "mid-stream reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule